// File: doc/BRIEF.md
# Pin I/O Controller with Change Interrupts

This block is a register-mapped controller for a bank of general-purpose pins (22 by default) behind a simple single-cycle 32-bit register bus. Software drives outputs through atomic set and clear words, or by writing the output latch directly. It chooses the direction of each pin with an enable word, and reads back the pin levels after a two-flop synchronizer.

Every transition of a synchronized pin level is recorded in a sticky pending word. Software clears pending bits by writing ones to them. An enable word masks the pending word to form an identity word, and a single interrupt line goes to the parent controller whenever that identity word is nonzero. Both-edge sensing comes straight from the hardware. Level-high sensing is handled by software, which acknowledges the event and re-reads the pin.

Each pin also carries a 2-bit function index, split across two bit-plane words. Index 0 leaves the pad with the GPIO logic. Any other index hands the pad's output value and output enable to an alternate peripheral outside the block, and the index is exported so that the peripheral side can route its own mux.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, `pad_oe` is all 0 and `func_sel` is all 0, so every pin starts as a GPIO input with its interrupt masked.
- R2: Writing word offset 0x00 sets each output-latch bit whose data bit is 1. Writing 0x04 clears each such bit. Zero data bits leave the latch unchanged. Offset 0x08 reads the latch and writes it directly. A write takes effect at the clock edge that samples it.
- R3: Offset 0x10 holds the output enables (1 = output). For a pin with function index 0, `pad_oe` equals its enable bit and `pad_out` equals its latch bit.
- R4: Offset 0x0C reads `pad_in` through a two-flop synchronizer. A pad change becomes visible after the second clock edge that follows it. Writes to 0x0C have no effect.
- R5: Any transition of a synchronized pin level sets that pin's bit in the pending word at 0x14. Writing 1 to a pending bit clears it, and written 0 bits leave pending bits unchanged.
- R6: When a pin event and a write of 1 to the same pending bit fall in the same cycle, the bit ends up set.
- R7: Offset 0x1C reads the pending word ANDed with the enable word at 0x18, and `irq` is 1 exactly when that identity word is nonzero. Writes to 0x1C have no effect.
- R8: Pin p's function index has bit 0 at bit p of offset 0x20 and bit 1 at bit p of offset 0x24. It appears on `func_sel[2p+1:2p]`.
- R9: For a pin with a nonzero function index, `pad_oe` equals `alt_oe[p]` and `pad_out` equals `alt_out[p]`. Clearing both function bits returns the pin to the GPIO values.
- R10: Bits 22 to 31 of the per-pin registers read 0. Offset 0x28 stores and returns a full 32-bit word. Unmapped or unaligned addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 8 | Byte address; word offsets are multiples of 4 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 22 | Pin levels from the pads (asynchronous) |
| pad_out | output | 22 | Output value to the pads |
| pad_oe | output | 22 | Output enable to the pads |
| alt_out | input | 22 | Output values from the alternate peripherals |
| alt_oe | input | 22 | Output enables from the alternate peripherals |
| func_sel | output | 44 | Per-pin 2-bit function index, pin p at [2p+1:2p] |
| irq | output | 1 | Aggregated interrupt to the parent controller |

## Verification
The hardest case to reach is an acknowledge write that lands in the very cycle in which a fresh transition of the same pin reaches the pending logic. To produce it, the bench first leaves the pin pending, then toggles the pad and counts the synchronizer's two edges, and drives the write-one-to-clear so that it is sampled on the exact edge where the new event is latched. A correct block keeps the bit set. A follow-up plain acknowledge then clears it. Random pad patterns, set and clear words and enable masks, checked against a bench model of the latch and the pending word, cover the ordinary traffic.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int unsigned DATA_W = 32;

    // word indices (byte offset / 4); software depends on these positions
    localparam int unsigned WI_SET   = 0;
    localparam int unsigned WI_CLR   = 1;
    localparam int unsigned WI_LATCH = 2;
    localparam int unsigned WI_LEVEL = 3;
    localparam int unsigned WI_DIR   = 4;
    localparam int unsigned WI_PEND  = 5;
    localparam int unsigned WI_MASK  = 6;
    localparam int unsigned WI_IDENT = 7;
    localparam int unsigned WI_FSEL0 = 8;
    localparam int unsigned WI_FSEL1 = 9;
    localparam int unsigned WI_SMAP  = 10;

    typedef enum logic [1:0] {
        FN_GPIO = 2'd0,
        FN_ALTA = 2'd1,
        FN_ALTB = 2'd2,
        FN_ALTC = 2'd3
    } pin_fn_e;

    typedef struct packed {
        logic out;
        logic oe;
    } pad_drive_t;

    function automatic pad_drive_t pick_drive(pin_fn_e fn, pad_drive_t gpio_d,
                                              pad_drive_t alt_d);
        return (fn == FN_GPIO) ? gpio_d : alt_d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned NPINS = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] level_o,
    output logic [NPINS-1:0] chg_o
);
    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign chg_o   = sync_q ^ prev_q;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
    parameter int unsigned NPINS = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] chg_i,
    input  logic             ack_we,
    input  logic             mask_we,
    input  logic [NPINS-1:0] wbits,
    output logic [NPINS-1:0] pend_o,
    output logic [NPINS-1:0] mask_o,
    output logic [NPINS-1:0] ident_o,
    output logic             irq_o
);
    logic [NPINS-1:0] pend_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] ack_bits;

    assign ack_bits = ack_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_bits) | chg_i;
            if (mask_we) mask_q <= wbits;
        end
    end

    assign pend_o  = pend_q;
    assign mask_o  = mask_q;
    assign ident_o = pend_q & mask_q;
    assign irq_o   = |ident_o;

    AST_PEND_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        (|(pend_q & ~$past(pend_q))) |-> $past(|chg_i)); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack_we && ((wbits & chg_i) == '0)) |=> ((pend_q & $past(wbits)) == '0)); // R5

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|chg_i) |=> ((pend_q & $past(chg_i)) == $past(chg_i))); // R6

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned NPINS = 22
) (
    input  logic [NPINS-1:0]   fsel0_i,
    input  logic [NPINS-1:0]   fsel1_i,
    input  logic [NPINS-1:0]   gpio_out_i,
    input  logic [NPINS-1:0]   gpio_oe_i,
    input  logic [NPINS-1:0]   alt_out_i,
    input  logic [NPINS-1:0]   alt_oe_i,
    output logic [NPINS-1:0]   pad_out_o,
    output logic [NPINS-1:0]   pad_oe_o,
    output logic [2*NPINS-1:0] func_sel_o
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_fn_e    fn;
        pad_drive_t gd;
        pad_drive_t ad;
        pad_drive_t sel;

        assign fn  = pin_fn_e'({fsel1_i[p], fsel0_i[p]});
        assign gd  = '{out: gpio_out_i[p], oe: gpio_oe_i[p]};
        assign ad  = '{out: alt_out_i[p], oe: alt_oe_i[p]};
        assign sel = pick_drive(fn, gd, ad);

        assign pad_out_o[p]          = sel.out;
        assign pad_oe_o[p]           = sel.oe;
        assign func_sel_o[2*p +: 2]  = fn;
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int unsigned NPINS  = 22,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NPINS-1:0]    pad_in,
    output logic [NPINS-1:0]    pad_out,
    output logic [NPINS-1:0]    pad_oe,
    input  logic [NPINS-1:0]    alt_out,
    input  logic [NPINS-1:0]    alt_oe,
    output logic [2*NPINS-1:0]  func_sel,
    output logic                irq
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             aligned;
    logic [NPINS-1:0] wbits;

    logic [NPINS-1:0]  latch_q, dir_q, fsel0_q, fsel1_q;
    logic [DATA_W-1:0] smap_q;
    logic [NPINS-1:0]  level, chg, pend, mask, ident;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wbits   = bus_wdata[NPINS-1:0];

    function automatic logic hit(logic [IDX_W-1:0] idx, logic al, int unsigned which);
        return al && (idx == IDX_W'(which));
    endfunction

    logic we_set, we_clr, we_latch, we_dir, we_pend, we_mask, we_f0, we_f1, we_smap;
    assign we_set   = bus_we && hit(widx, aligned, WI_SET);
    assign we_clr   = bus_we && hit(widx, aligned, WI_CLR);
    assign we_latch = bus_we && hit(widx, aligned, WI_LATCH);
    assign we_dir   = bus_we && hit(widx, aligned, WI_DIR);
    assign we_pend  = bus_we && hit(widx, aligned, WI_PEND);
    assign we_mask  = bus_we && hit(widx, aligned, WI_MASK);
    assign we_f0    = bus_we && hit(widx, aligned, WI_FSEL0);
    assign we_f1    = bus_we && hit(widx, aligned, WI_FSEL1);
    assign we_smap  = bus_we && hit(widx, aligned, WI_SMAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            fsel0_q <= '0;
            fsel1_q <= '0;
            smap_q  <= '0;
        end else begin
            if (we_set)   latch_q <= latch_q | wbits;
            if (we_clr)   latch_q <= latch_q & ~wbits;
            if (we_latch) latch_q <= wbits;
            if (we_dir)   dir_q   <= wbits;
            if (we_f0)    fsel0_q <= wbits;
            if (we_f1)    fsel1_q <= wbits;
            if (we_smap)  smap_q  <= bus_wdata;
        end
    end

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .level_o (level),
        .chg_o   (chg)
    );

    gpio_irq_bank #(.NPINS(NPINS)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .chg_i   (chg),
        .ack_we  (we_pend),
        .mask_we (we_mask),
        .wbits   (wbits),
        .pend_o  (pend),
        .mask_o  (mask),
        .ident_o (ident),
        .irq_o   (irq)
    );

    gpio_pin_mux #(.NPINS(NPINS)) u_mux (
        .fsel0_i    (fsel0_q),
        .fsel1_i    (fsel1_q),
        .gpio_out_i (latch_q),
        .gpio_oe_i  (dir_q),
        .alt_out_i  (alt_out),
        .alt_oe_i   (alt_oe),
        .pad_out_o  (pad_out),
        .pad_oe_o   (pad_oe),
        .func_sel_o (func_sel)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (widx)
                IDX_W'(WI_LATCH): bus_rdata[NPINS-1:0] = latch_q;
                IDX_W'(WI_LEVEL): bus_rdata[NPINS-1:0] = level;
                IDX_W'(WI_DIR):   bus_rdata[NPINS-1:0] = dir_q;
                IDX_W'(WI_PEND):  bus_rdata[NPINS-1:0] = pend;
                IDX_W'(WI_MASK):  bus_rdata[NPINS-1:0] = mask;
                IDX_W'(WI_IDENT): bus_rdata[NPINS-1:0] = ident;
                IDX_W'(WI_FSEL0): bus_rdata[NPINS-1:0] = fsel0_q;
                IDX_W'(WI_FSEL1): bus_rdata[NPINS-1:0] = fsel1_q;
                IDX_W'(WI_SMAP):  bus_rdata = smap_q;
                default:          bus_rdata = '0;
            endcase
        end
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        we_set |=> ((latch_q & $past(wbits)) == $past(wbits))); // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        we_clr |=> ((latch_q & $past(wbits)) == '0)); // R2

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(we_set || we_clr || we_latch) |=> $stable(latch_q)); // R2

    AST_FSEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(we_f0 || we_f1) |=> $stable(func_sel)); // R8

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
    localparam int N = 22;
    localparam logic [31:0] PM = (32'd1 << N) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pad_in = '0, pad_out, pad_oe, alt_out = '0, alt_oe = '0;
    logic [2*N-1:0] func_sel;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [31:0] m_latch = 0, m_dir = 0, m_pend = 0, m_mask = 0;

    always #5 clk = ~clk;

    gpio_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
        .func_sel(func_sel), .irq(irq)
    );

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] ident_of(logic [31:0] p, logic [31:0] m);
        return p & m;
    endfunction

    task automatic drive_pads(logic [N-1:0] v);
        @(negedge clk);
        m_pend = m_pend | ({10'd0, pad_in ^ v});
        pad_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 11; a++) begin
            rd(8'(a * 4), r);
            chk("R1 reg", {32'd0, r}, 64'd0);
        end
        chk("R1 irq/oe/fsel", {19'd0, irq, pad_oe, func_sel[21:0]}, 64'd0);

        // R2 set/clear and R10 upper bits
        wr(8'h00, 32'hFFFF_FFFF); m_latch = PM;
        rd(8'h08, r); chk("R2/R10 set all", {32'd0, r}, {32'd0, PM});
        wr(8'h04, 32'h0000_00F0); m_latch &= ~32'hF0;
        rd(8'h08, r); chk("R2 clear", {32'd0, r}, {32'd0, m_latch});
        wr(8'h00, 32'h0); wr(8'h04, 32'h0);
        rd(8'h08, r); chk("R2 zero write", {32'd0, r}, {32'd0, m_latch});

        // R3 direction and pad drive
        wr(8'h10, 32'h0015_5555); m_dir = 32'h0015_5555;
        #1 chk("R3 pad_oe", {42'd0, pad_oe}, {42'd0, m_dir[N-1:0]});
        chk("R3 pad_out", {42'd0, pad_out}, {42'd0, m_latch[N-1:0]});

        // R10 map word, unmapped and unaligned
        wr(8'h28, 32'hDEAD_BEEF);
        rd(8'h28, r); chk("R10 map word", {32'd0, r}, 64'hDEAD_BEEF);
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h2C, r); chk("R10 unmapped", {32'd0, r}, 64'd0);
        wr(8'h09, 32'h0);
        rd(8'h08, r); chk("R10 unaligned write", {32'd0, r}, {32'd0, m_latch});
        rd(8'h0A, r); chk("R10 unaligned read", {32'd0, r}, 64'd0);

        // R4 two-flop latency, writes ignored
        @(negedge clk); bus_addr = 8'h0C; pad_in = 22'h00_0001;
        m_pend |= 32'h1;
        @(negedge clk); #1 chk("R4 one edge", {32'd0, bus_rdata}, 64'd0);
        @(negedge clk); #1 chk("R4 two edges", {32'd0, bus_rdata}, 64'd1);
        wr(8'h0C, 32'h0);
        rd(8'h0C, r); chk("R4 write ignored", {32'd0, r}, 64'd1);
        rd(8'h14, r); chk("R5 pending from edge", {32'd0, r}, {32'd0, m_pend});

        // R7 mask and identity
        chk("R7 irq masked", {63'd0, irq}, 64'd0);
        wr(8'h18, 32'h1); m_mask = 32'h1;
        rd(8'h1C, r); chk("R7 ident", {32'd0, r}, {32'd0, ident_of(m_pend, m_mask)});
        chk("R7 irq", {63'd0, irq}, 64'd1);
        wr(8'h1C, 32'h0);
        rd(8'h1C, r); chk("R7 ident write ignored", {32'd0, r}, 64'd1);
        wr(8'h14, 32'h1); m_pend &= ~32'h1;
        rd(8'h14, r); chk("R5 ack", {32'd0, r}, {32'd0, m_pend});
        chk("R7 irq drops", {63'd0, irq}, 64'd0);

        // R6 event wins over same-cycle ack on pin 7
        drive_pads(pad_in ^ 22'h80);
        rd(8'h14, r); chk("R6 pre pending", {63'd0, r[7]}, 64'd1);
        @(negedge clk); pad_in[7] = ~pad_in[7];
        @(negedge clk);
        @(negedge clk); bus_we = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h80;
        @(negedge clk); bus_we = 1'b0;
        rd(8'h14, r); chk("R6 event beats ack", {63'd0, r[7]}, 64'd1);
        repeat (3) @(negedge clk);
        wr(8'h14, 32'h80); m_pend &= ~32'h80;
        rd(8'h14, r); chk("R6 later ack clears", {63'd0, r[7]}, 64'd0);

        // R8 / R9 function select
        alt_oe = 22'h00_0028; alt_out = 22'h00_0020;
        wr(8'h20, 32'h08);
        wr(8'h24, 32'h28);
        chk("R8 pin3 index", {62'd0, func_sel[7:6]}, 64'd3);
        chk("R8 pin5 index", {62'd0, func_sel[11:10]}, 64'd2);
        chk("R9 pin3 oe alt", {63'd0, pad_oe[3]}, 64'd1);
        chk("R9 pin5 out alt", {63'd0, pad_out[5]}, 64'd1);
        wr(8'h20, 32'h0); wr(8'h24, 32'h0);
        chk("R9 back to gpio oe", {42'd0, pad_oe}, {42'd0, m_dir[N-1:0]});
        chk("R9 back to gpio out", {42'd0, pad_out}, {42'd0, m_latch[N-1:0]});
        alt_oe = '0; alt_out = '0;

        // random traffic
        for (int i = 0; i < 60; i++) begin
            logic [31:0] d;
            d = $urandom;
            case ($urandom % 6)
                0: begin wr(8'h00, d); m_latch |= d & PM; end
                1: begin wr(8'h04, d); m_latch &= ~d; end
                2: begin wr(8'h08, d); m_latch = d & PM; end
                3: drive_pads(N'($urandom));
                4: begin wr(8'h14, d); m_pend &= ~d; end
                default: begin wr(8'h18, d); m_mask = d & PM; end
            endcase
            rd(8'h08, r); chk("R2 random latch", {32'd0, r}, {32'd0, m_latch});
            rd(8'h0C, r); chk("R4 random level", {32'd0, r}, {42'd0, pad_in});
            rd(8'h14, r); chk("R5 random pending", {32'd0, r}, {32'd0, m_pend});
            rd(8'h1C, r); chk("R7 random ident", {32'd0, r}, {32'd0, ident_of(m_pend, m_mask)});
            chk("R7 random irq", {63'd0, irq}, {63'd0, |ident_of(m_pend, m_mask)});
            chk("R3 random pad_out", {42'd0, pad_out}, {42'd0, m_latch[N-1:0]});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule